// File: doc/BRIEF.md
# Register Stack Save/Restore Sequencer

This block saves or restores any chosen set of machine registers on a memory stack, one byte per clock, through a byte-wide memory port. A one-cycle start strobe launches an operation. With it come a direction (save or restore), the choice of active stack pointer (system or user), an 8-bit selection mask and the current register values. The block holds the register values and the active pointer for the whole operation. It then walks the selected registers in a fixed priority order, and that order is reversed for a restore.

During a save, every byte first moves the pointer down by one and is then written at the new address. During a restore, every byte is read at the pointer, which then moves up by one. Sixteen-bit registers sit in memory with the high byte at the lower address. When a restored register is complete, the block presents its value together with a one-hot load strobe, so the register file next to the block can take it. At the end of the operation the final pointer is available and a one-cycle done pulse is raised.

Top module: `stack_seq`

## Requirements
- R1: Mask bit positions select registers as follows: 0 = CC, 1 = A, 2 = B, 3 = DP, 4 = X, 5 = Y, 6 = the inactive stack pointer, 7 = PC. Each bit of `ld_en_o` belongs to the register of the same mask bit.
- R2: Save writes each byte at (pointer − 1) and leaves the pointer one lower. Consecutive write addresses within one operation fall by exactly one.
- R3: Restore reads each byte at the pointer and leaves the pointer one higher. Consecutive read addresses within one operation rise by exactly one.
- R4: Save emits the selected registers from mask bit 7 down to mask bit 0.
- R5: Restore loads the selected registers from mask bit 0 up to mask bit 7, so PC is loaded last.
- R6: Bits 7..4 select 16-bit registers and bits 3..0 select 8-bit registers. A save writes a 16-bit register low byte first and high byte second. A restore reads the high byte first and presents the full word on `ld_data_o`. An 8-bit register is presented zero-extended.
- R7: `ld_en_o` is one-hot or zero. It is high only in a restore cycle that reads the last byte of a register, and never during a save.
- R8: A zero mask raises `done_o` in the cycle after the start, performs no memory access and leaves `sp_o` equal to the active pointer.
- R9: A start strobe that arrives while an operation is in progress is ignored.
- R10: An operation of N bytes occupies exactly N consecutive access cycles. `done_o` is high for the one cycle that follows, and at that point `sp_o` holds the final pointer. No memory access happens while `done_o` is high.
- R11: With the user pointer active, mask bit 6 saves and restores the system pointer. With the system pointer active, it saves and restores the user pointer.
- R12: A mask of FF moves all eight registers in 12 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, one cycle |
| pull_i | input | 1 | 1 = restore, 0 = save |
| user_i | input | 1 | 1 = user pointer active, 0 = system pointer active |
| mask_i | input | 8 | Register selection mask |
| pc_i | input | 16 | Program counter value |
| sys_sp_i | input | 16 | System stack pointer value |
| usr_sp_i | input | 16 | User stack pointer value |
| y_i | input | 16 | Index register Y value |
| x_i | input | 16 | Index register X value |
| dp_i | input | 8 | Direct page register value |
| b_i | input | 8 | Accumulator B value |
| a_i | input | 8 | Accumulator A value |
| cc_i | input | 8 | Condition code value |
| mem_rdata_i | input | 8 | Read data, valid in the same cycle as `mem_re_o` |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_we_o | output | 1 | Write enable |
| mem_re_o | output | 1 | Read enable |
| ld_data_o | output | 16 | Restored register value |
| ld_en_o | output | 8 | One-hot load strobe, indexed like the mask |
| sp_o | output | 16 | Active stack pointer after the operation |
| done_o | output | 1 | Completion pulse |

## Verification
The start strobe is captured at a rising edge. The first memory access appears in the cycle after that edge, and every later byte follows one cycle apart. A load strobe is combinational in the cycle that reads a register's last byte. `done_o` and the final `sp_o` are registered and appear in the cycle after the last access; with a zero mask they appear in the cycle directly after the start. The bench drives inputs and samples outputs at falling edges. It walks the access cycles one at a time and compares each cycle against a byte list built from the requirements. It then expects `done_o` in exactly the next sample and expects it to be low one sample later.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;
  localparam int NREG   = 8;
  localparam int REG_W  = 16;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = $clog2(NREG);
  // slots at or above this index are 16-bit
  localparam int WIDE_FIRST = 4;

  typedef enum logic [IDX_W-1:0] {
    SLOT_CC  = 3'd0,
    SLOT_A   = 3'd1,
    SLOT_B   = 3'd2,
    SLOT_DP  = 3'd3,
    SLOT_X   = 3'd4,
    SLOT_Y   = 3'd5,
    SLOT_OSP = 3'd6,
    SLOT_PC  = 3'd7
  } slot_e;

  function automatic logic slot_wide(logic [IDX_W-1:0] s);
    return s >= IDX_W'(WIDE_FIRST);
  endfunction
endpackage

// File: rtl/stack_seq_pick.sv
// Picks the next pending slot: highest for save, lowest for restore.
module stack_seq_pick #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend_i,
  input  logic          pull_i,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    if (pull_i) begin
      for (int i = N-1; i >= 0; i--) if (pend_i[i]) idx_o = IW'(i);
    end else begin
      for (int i = 0; i < N; i++) if (pend_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/stack_seq_bsel.sv
// Byte select out of the held register values.
module stack_seq_bsel #(
  parameter int N  = 8,
  parameter int W  = 16,
  parameter int BW = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0][W-1:0] vals_i,
  input  logic [IW-1:0]       idx_i,
  input  logic                hi_i,
  output logic [BW-1:0]       byte_o
);
  logic [W-1:0] word;
  assign word   = vals_i[idx_i];
  assign byte_o = hi_i ? word[W-1:W-BW] : word[BW-1:0];
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                pull_i,
  input  logic                user_i,
  input  logic [NREG-1:0]     mask_i,
  input  logic [REG_W-1:0]    pc_i,
  input  logic [REG_W-1:0]    sys_sp_i,
  input  logic [REG_W-1:0]    usr_sp_i,
  input  logic [REG_W-1:0]    y_i,
  input  logic [REG_W-1:0]    x_i,
  input  logic [BYTE_W-1:0]   dp_i,
  input  logic [BYTE_W-1:0]   b_i,
  input  logic [BYTE_W-1:0]   a_i,
  input  logic [BYTE_W-1:0]   cc_i,
  input  logic [BYTE_W-1:0]   mem_rdata_i,
  output logic [REG_W-1:0]    mem_addr_o,
  output logic [BYTE_W-1:0]   mem_wdata_o,
  output logic                mem_we_o,
  output logic                mem_re_o,
  output logic [REG_W-1:0]    ld_data_o,
  output logic [NREG-1:0]     ld_en_o,
  output logic [REG_W-1:0]    sp_o,
  output logic                done_o
);
  localparam logic [BYTE_W-1:0] ZB = '0;

  logic                       busy_q, pull_q, phase_q, done_q;
  logic [NREG-1:0]            pend_q, pend_nx;
  logic [REG_W-1:0]           sp_q;
  logic [BYTE_W-1:0]          hi_q;
  logic [NREG-1:0][REG_W-1:0] vals_q;
  logic [IDX_W-1:0]           cur;
  logic                       wide, last, accept;
  logic [BYTE_W-1:0]          wbyte;
  logic [REG_W-1:0]           other_sp;

  assign accept   = start_i && !busy_q;
  assign other_sp = user_i ? sys_sp_i : usr_sp_i;

  stack_seq_pick #(.N(NREG)) u_pick (
    .pend_i (pend_q),
    .pull_i (pull_q),
    .idx_o  (cur)
  );

  stack_seq_bsel #(.N(NREG), .W(REG_W), .BW(BYTE_W)) u_bsel (
    .vals_i (vals_q),
    .idx_i  (cur),
    .hi_i   (phase_q),
    .byte_o (wbyte)
  );

  assign wide = slot_wide(cur);
  assign last = !wide || phase_q;

  always_comb begin
    pend_nx = pend_q;
    if (last) pend_nx[cur] = 1'b0;
  end

  assign mem_addr_o  = pull_q ? sp_q : sp_q - REG_W'(1);
  assign mem_wdata_o = wbyte;
  assign mem_we_o    = busy_q && !pull_q;
  assign mem_re_o    = busy_q && pull_q;
  assign ld_en_o     = (busy_q && pull_q && last) ? (NREG'(1) << cur) : '0;
  assign ld_data_o   = wide ? {hi_q, mem_rdata_i} : {ZB, mem_rdata_i};
  assign sp_o        = sp_q;
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      pull_q  <= 1'b0;
      phase_q <= 1'b0;
      done_q  <= 1'b0;
      pend_q  <= '0;
      sp_q    <= '0;
      hi_q    <= '0;
      vals_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        pull_q  <= pull_i;
        sp_q    <= user_i ? usr_sp_i : sys_sp_i;
        pend_q  <= mask_i;
        phase_q <= 1'b0;
        busy_q  <= |mask_i;
        done_q  <= ~|mask_i;
        vals_q  <= {pc_i, other_sp, y_i, x_i,
                    {ZB, dp_i}, {ZB, b_i}, {ZB, a_i}, {ZB, cc_i}};
      end else if (busy_q) begin
        sp_q    <= pull_q ? sp_q + REG_W'(1) : sp_q - REG_W'(1);
        phase_q <= !last;
        if (pull_q && !last) hi_q <= mem_rdata_i;
        pend_q  <= pend_nx;
        if (pend_nx == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [7:0]  mask_i,
  input logic        busy_i,
  input logic        we_i,
  input logic        re_i,
  input logic [15:0] addr_i,
  input logic [7:0]  ld_en_i,
  input logic        done_i
);
  assert_rw_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && re_i));
  assert_ld_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ld_en_i));
  assert_ld_on_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_en_i != 8'h00) |-> re_i);
  assert_push_dec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && $past(we_i)) |-> (addr_i == $past(addr_i) - 16'd1));
  assert_pull_inc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && $past(re_i)) |-> (addr_i == $past(addr_i) + 16'd1));
  assert_zero_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i && mask_i == 8'h00) |=> (done_i && !we_i && !re_i));
  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (!we_i && !re_i));
endmodule

bind stack_seq stack_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .mask_i  (mask_i),
  .busy_i  (busy_q),
  .we_i    (mem_we_o),
  .re_i    (mem_re_o),
  .addr_i  (mem_addr_o),
  .ld_en_i (ld_en_o),
  .done_i  (done_o)
);

// File: tb/tb_stack_seq.sv
module tb_stack_seq;
  localparam logic [15:0] PC_V = 16'hA1B2, Y_V = 16'h3344, X_V = 16'h5566;
  localparam logic [15:0] SYS0 = 16'h0080, USR0 = 16'h00C0;
  localparam logic [7:0]  DP_V = 8'h7D, B_V = 8'h9E, A_V = 8'h2F, CC_V = 8'hC3;
  // {user, mask, expected byte count}
  localparam logic [12:0] VEC [6] = '{
    {1'b0, 8'hFF, 4'd12}, {1'b1, 8'hFF, 4'd12}, {1'b0, 8'h81, 4'd3},
    {1'b1, 8'h40, 4'd2},  {1'b0, 8'h0E, 4'd3},  {1'b1, 8'h30, 4'd4}};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, start = 1'b0, pull = 1'b0, user = 1'b0;
  logic [7:0]  mask = '0;
  logic [15:0] sys_sp = SYS0, usr_sp = USR0;
  logic [7:0]  rdata;
  logic [15:0] addr, ld_data, sp;
  logic [7:0]  wdata, ld_en;
  logic        we, re, done;
  logic [7:0]  tmem [256];

  assign rdata = tmem[addr[7:0]];

  stack_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pull_i(pull), .user_i(user),
    .mask_i(mask), .pc_i(PC_V), .sys_sp_i(sys_sp), .usr_sp_i(usr_sp),
    .y_i(Y_V), .x_i(X_V), .dp_i(DP_V), .b_i(B_V), .a_i(A_V), .cc_i(CC_V),
    .mem_rdata_i(rdata), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_we_o(we), .mem_re_o(re), .ld_data_o(ld_data), .ld_en_o(ld_en),
    .sp_o(sp), .done_o(done));

  int total = 0, fails = 0, cyc = 0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; fails++;
      $display("FAIL R10 watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  function automatic logic [15:0] word_of(int s, logic u);
    case (s)
      7: return PC_V;
      6: return u ? SYS0 : USR0;
      5: return Y_V;
      4: return X_V;
      3: return {8'h00, DP_V};
      2: return {8'h00, B_V};
      1: return {8'h00, A_V};
      default: return {8'h00, CC_V};
    endcase
  endfunction

  function automatic int nbytes(logic [7:0] m);
    int n = 0;
    for (int s = 0; s < 8; s++) if (m[s]) n += (s >= 4) ? 2 : 1;
    return n;
  endfunction

  task automatic do_push(input logic u, input logic [7:0] m, input int exp_n, input logic poke);
    logic [7:0]  e_data [16];
    logic [15:0] sp0, ea;
    int n = 0, k = 0, reads = 0;
    logic ld_seen = 1'b0;
    logic [15:0] w;
    sp0 = u ? USR0 : SYS0;
    for (int s = 7; s >= 0; s--) if (m[s]) begin
      w = word_of(s, u);
      e_data[n] = w[7:0]; n++;
      if (s >= 4) begin e_data[n] = w[15:8]; n++; end
    end
    chk(n == exp_n, "R6 byte count model", n, exp_n);
    @(negedge clk);
    pull = 1'b0; user = u; mask = m; sys_sp = SYS0; usr_sp = USR0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 40 && !done; c++) begin
      if (poke && k == 3) begin start = 1'b1; pull = 1'b1; mask = 8'h01; end
      else if (poke && k == 4) begin start = 1'b0; pull = 1'b0; end
      if (we) begin
        ea = sp0 - 16'(k) - 16'd1;
        chk(addr == ea, "R2 push address", addr, ea);
        chk(k < n && wdata == e_data[k], "R4 push byte order", wdata, e_data[k]);
        tmem[addr[7:0]] = wdata;
        k++;
      end
      if (re) reads++;
      if (ld_en != 8'h00) ld_seen = 1'b1;
      @(negedge clk);
    end
    chk(done, "R10 done after last byte", done, 1);
    chk(k == n, (m == 8'hFF) ? "R12 all-register byte count" : "R10 byte count", k, n);
    chk(sp == sp0 - 16'(n), "R2 final pointer", sp, sp0 - 16'(n));
    chk(!ld_seen, "R7 no load strobe on save", ld_seen, 0);
    if (poke) chk(reads == 0, "R9 start while busy ignored", reads, 0);
    @(negedge clk);
    chk(!done, "R10 done one cycle", done, 0);
  endtask

  task automatic do_pull(input logic u, input logic [7:0] m);
    int          e_slot [8];
    logic [15:0] e_val  [8];
    logic [15:0] sp0, ea;
    int n, cnt = 0, j = 0, k = 0;
    n   = nbytes(m);
    sp0 = (u ? USR0 : SYS0) - 16'(n);
    for (int s = 0; s < 8; s++) if (m[s]) begin
      e_slot[cnt] = s; e_val[cnt] = word_of(s, u); cnt++;
    end
    @(negedge clk);
    pull = 1'b1; user = u; mask = m;
    sys_sp = u ? SYS0 : sp0; usr_sp = u ? sp0 : USR0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 40 && !done; c++) begin
      if (re) begin
        ea = sp0 + 16'(k);
        chk(addr == ea, "R3 pull address", addr, ea);
        k++;
      end
      if (ld_en != 8'h00) begin
        chk(j < cnt && ld_en == (8'h01 << e_slot[j]), "R1 R5 load strobe order", ld_en, 8'h01 << e_slot[j]);
        chk(j < cnt && ld_data == e_val[j], (e_slot[j] == 6) ? "R11 other pointer value" : "R6 restored value",
            ld_data, e_val[j]);
        j++;
      end
      @(negedge clk);
    end
    chk(j == cnt, "R5 loads per restore", j, cnt);
    chk(k == n, "R10 restore byte count", k, n);
    chk(sp == sp0 + 16'(n), "R3 final pointer", sp, sp0 + 16'(n));
    @(negedge clk);
    chk(!done, "R10 done one cycle", done, 0);
    pull = 1'b0; sys_sp = SYS0; usr_sp = USR0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) tmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!we && !re && !done && ld_en == 8'h00, "R10 reset idle", {we, re, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      do_push(VEC[i][12], VEC[i][11:4], int'(VEC[i][3:0]), 1'b0);
      do_pull(VEC[i][12], VEC[i][11:4]);
    end

    // R8 zero mask
    @(negedge clk);
    pull = 1'b0; user = 1'b0; mask = 8'h00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done, "R8 zero mask done", done, 1);
    chk(!we && !re, "R8 zero mask no access", {we, re}, 0);
    chk(sp == SYS0, "R8 zero mask pointer", sp, SYS0);
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);

    // R9 start during a save
    do_push(1'b0, 8'hFF, 12, 1'b1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule